// File: doc/BRIEF.md
# Light-Load Burst Gate Controller

This block sits between a fixed-frequency PWM pulse source and the gate driver of a flyback converter. It decides, pulse by pulse, whether a PWM pulse reaches the driver while the converter runs at light load. Four comparator flags describe where the feedback voltage lies against four thresholds (600, 500, 400 and 300 mV). A flag is high while the feedback is above its threshold.

Once the feedback falls under the top threshold, the controller leaves normal operation. It walks through a falling sequence: full switching (FALL), then partial skipping (SKIP), then full switching again (LATE). It then stops all switching (OFF) until the feedback climbs back over the lowest threshold. It then switches fully again (RISE) until the feedback is back above the top threshold. From RISE it either repeats the falling sequence or, if the feedback stays high long enough, returns to normal operation (NORMAL).

Every flag is synchronised and debounced before it is used. Gating decisions are taken only when a PWM pulse begins, so no pulse is ever cut short. The current state is visible on a 3-bit mode output.

Top module: `burst_gate_ctrl`

## Requirements
- R1: Reset is synchronous and active high. It places the block in NORMAL (mode 0) with the gate output low, clears the skip counter, and sets all filtered flags to "above threshold".
- R2: Each comparator flag passes through two synchronising flops. A change is accepted only after it has persisted for FILT_LEN (4) consecutive clock cycles, so a 3-cycle glitch has no effect on the mode.
- R3: In NORMAL every PWM pulse reaches the gate output. When the feedback is below 600 mV, the block moves to FALL (mode 1).
- R4: In FALL every pulse passes. The lowest threshold the feedback is below selects the next state: below 300 mV goes to OFF, below 400 mV goes to LATE, and below 500 mV goes to SKIP (mode 2).
- R5: In SKIP, pulses are numbered from 0 starting at entry to the state. A pulse passes only when its number modulo SKIP_MOD (5) is below SKIP_PASS (2), so 60% of pulses are suppressed.
- R6: From SKIP, feedback below 400 mV moves to LATE (mode 3), where every pulse passes. From SKIP or LATE, feedback below 300 mV moves to OFF (mode 4).
- R7: In OFF no pulse reaches the gate output. Feedback back above 300 mV moves to RISE (mode 5).
- R8: In RISE every pulse passes. Feedback below 300 mV moves to OFF. If the feedback has been above 600 mV in this visit and then drops below it, the block moves to FALL.
- R9: In RISE, the count of pulses that begin while the feedback is above 600 mV is kept. When it reaches EXIT_PERIODS, the block returns to NORMAL; the count restarts whenever the feedback drops below 600 mV.
- R10: The pass/block decision is taken at the first cycle of each pulse and held for the whole pulse. A passed pulse is never truncated, even if the state changes during it.
- R11: The mode output encodes NORMAL=0, FALL=1, SKIP=2, LATE=3, OFF=4, RISE=5, and never shows any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_gt_600 | input | 1 | Feedback above 600 mV (asynchronous) |
| fb_gt_500 | input | 1 | Feedback above 500 mV (asynchronous) |
| fb_gt_400 | input | 1 | Feedback above 400 mV (asynchronous) |
| fb_gt_300 | input | 1 | Feedback above 300 mV (asynchronous) |
| pwm_in | input | 1 | PWM pulse stream from the oscillator, synchronous to clk |
| gate_out | output | 1 | Gated pulse stream to the driver |
| mode | output | 3 | Current controller state |

## Verification
The bench builds the block with FILT_LEN 4, SKIP_MOD 5 and SKIP_PASS 2, and lowers EXIT_PERIODS from 16 to 4. The lower exit count lets the return to NORMAL be checked one pulse before and one pulse after the limit. The bench steps the feedback through every band, in both directions and also with direct jumps. It runs the skip pattern over two full periods of five pulses, checking each pulse's expected pass or block from its index. It also drops the flags in the middle of a long pulse and applies a reset partway through a skip run.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
    localparam int NUM_LVL = 4;

    typedef enum logic [2:0] {
        M_NORMAL = 3'd0,
        M_FALL   = 3'd1,
        M_SKIP   = 3'd2,
        M_LATE   = 3'd3,
        M_OFF    = 3'd4,
        M_RISE   = 3'd5
    } mode_e;
endpackage

// File: rtl/bgc_flag_filter.sv
module bgc_flag_filter #(
    parameter int   FILT_LEN = 4,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic flag
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic          s1_q, s2_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= raw;
            s2_q <= s1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= RST_VAL;
            cnt_q <= '0;
        end else if (s2_q == flag) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            flag  <= s2_q;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: an accepted flag value is the one the synchroniser held just before
    p_filter_follows_sync_r2: assert property (@(posedge clk) disable iff (rst)
        (flag != $past(flag)) |-> ($past(s2_q) == flag));
endmodule

// File: rtl/bgc_pulse_gate.sv
module bgc_pulse_gate #(
    parameter int SKIP_MOD  = 5,
    parameter int SKIP_PASS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    input  logic run_allow,
    input  logic in_skip,
    output logic pwm_rise,
    output logic gate_out
);
    localparam int CW = (SKIP_MOD > 1) ? $clog2(SKIP_MOD) : 1;
    localparam logic [CW-1:0] WRAP   = CW'(SKIP_MOD - 1);
    localparam logic [CW-1:0] PASS_N = CW'(SKIP_PASS);

    logic          pwm_q;
    logic          pass_hold_q;
    logic [CW-1:0] skip_cnt_q;
    logic          allow;
    logic          pass_now;

    always_comb begin
        pwm_rise = pwm_in & ~pwm_q;
        allow    = run_allow | (in_skip & (skip_cnt_q < PASS_N));
        pass_now = pwm_rise ? allow : pass_hold_q;
        gate_out = pwm_in & pass_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q       <= 1'b0;
            pass_hold_q <= 1'b0;
        end else begin
            pwm_q       <= pwm_in;
            pass_hold_q <= pwm_in & pass_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !in_skip) begin
            skip_cnt_q <= '0;
        end else if (pwm_rise) begin
            skip_cnt_q <= (skip_cnt_q == WRAP) ? '0 : skip_cnt_q + 1'b1;
        end
    end

    // R5: the skip phase counter stays inside its modulus
    p_skip_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
        skip_cnt_q <= WRAP);
    // R10: a passed pulse continues while the source pulse continues
    p_no_truncation_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(gate_out) && pwm_in) |-> gate_out);
    // R10: gate can only rise together with the source pulse rising
    p_gate_starts_with_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (gate_out && !$past(gate_out)) |-> !$past(pwm_in));
endmodule

// File: rtl/bgc_fsm.sv
module bgc_fsm
    import bgc_pkg::*;
#(
    parameter int EXIT_PERIODS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] lvl,
    input  logic               pwm_rise,
    output mode_e              state,
    output logic               run_allow,
    output logic               in_skip
);
    localparam int EW = $clog2(EXIT_PERIODS + 1);
    localparam logic [EW-1:0] EXIT_LAST = EW'(EXIT_PERIODS - 1);

    mode_e         nxt;
    logic          peaked_q;
    logic [EW-1:0] exit_cnt_q;
    logic          above300, above400, above500, above600;

    assign above300 = lvl[0];
    assign above400 = lvl[1];
    assign above500 = lvl[2];
    assign above600 = lvl[3];

    always_ff @(posedge clk) begin
        if (rst) state <= M_NORMAL;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            M_NORMAL: if (!above600) nxt = M_FALL;
            M_FALL: begin
                if (!above300)      nxt = M_OFF;
                else if (!above400) nxt = M_LATE;
                else if (!above500) nxt = M_SKIP;
            end
            M_SKIP: begin
                if (!above300)      nxt = M_OFF;
                else if (!above400) nxt = M_LATE;
            end
            M_LATE: if (!above300) nxt = M_OFF;
            M_OFF:  if (above300)  nxt = M_RISE;
            M_RISE: begin
                if (!above300)
                    nxt = M_OFF;
                else if (peaked_q && !above600)
                    nxt = M_FALL;
                else if (above600 && pwm_rise && exit_cnt_q == EXIT_LAST)
                    nxt = M_NORMAL;
            end
            default: nxt = M_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || state != M_RISE) begin
            peaked_q   <= 1'b0;
            exit_cnt_q <= '0;
        end else if (!above600) begin
            exit_cnt_q <= '0;
        end else begin
            peaked_q <= 1'b1;
            if (pwm_rise) exit_cnt_q <= exit_cnt_q + 1'b1;
        end
    end

    always_comb begin
        run_allow = (state == M_NORMAL) || (state == M_FALL) ||
                    (state == M_LATE)   || (state == M_RISE);
        in_skip   = (state == M_SKIP);
    end

    // R11: only the six defined codes appear
    p_mode_legal_r11: assert property (@(posedge clk) disable iff (rst)
        state <= M_RISE);
    // R7: OFF is left only towards RISE
    p_off_exit_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == M_OFF && state != M_OFF) |-> state == M_RISE);
    // R6: entering OFF requires feedback below the lowest threshold
    p_off_entry_r6: assert property (@(posedge clk) disable iff (rst)
        (state == M_OFF && $past(state) != M_OFF) |-> !$past(above300));
    // R9: return to NORMAL from RISE only with feedback above the top threshold
    p_normal_return_r9: assert property (@(posedge clk) disable iff (rst)
        (state == M_NORMAL && $past(state) == M_RISE) |-> $past(above600));
endmodule

// File: rtl/burst_gate_ctrl.sv
module burst_gate_ctrl
    import bgc_pkg::*;
#(
    parameter int FILT_LEN     = 4,
    parameter int SKIP_MOD     = 5,
    parameter int SKIP_PASS    = 2,
    parameter int EXIT_PERIODS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fb_gt_600,
    input  logic       fb_gt_500,
    input  logic       fb_gt_400,
    input  logic       fb_gt_300,
    input  logic       pwm_in,
    output logic       gate_out,
    output logic [2:0] mode
);
    logic [NUM_LVL-1:0] raw_lvl;
    logic [NUM_LVL-1:0] lvl;
    logic               pwm_rise;
    logic               run_allow;
    logic               in_skip;
    mode_e              state;

    assign raw_lvl = {fb_gt_600, fb_gt_500, fb_gt_400, fb_gt_300};

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_flt
        bgc_flag_filter #(
            .FILT_LEN(FILT_LEN),
            .RST_VAL (1'b1)
        ) u_flt (
            .clk (clk),
            .rst (rst),
            .raw (raw_lvl[g]),
            .flag(lvl[g])
        );
    end

    bgc_fsm #(
        .EXIT_PERIODS(EXIT_PERIODS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .pwm_rise (pwm_rise),
        .state    (state),
        .run_allow(run_allow),
        .in_skip  (in_skip)
    );

    bgc_pulse_gate #(
        .SKIP_MOD (SKIP_MOD),
        .SKIP_PASS(SKIP_PASS)
    ) u_gate (
        .clk      (clk),
        .rst      (rst),
        .pwm_in   (pwm_in),
        .run_allow(run_allow),
        .in_skip  (in_skip),
        .pwm_rise (pwm_rise),
        .gate_out (gate_out)
    );

    assign mode = state;

    // R7: a pulse that begins in OFF never reaches the driver
    p_off_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (pwm_rise && state == M_OFF) |-> !gate_out);
    // R1: the cycle after reset shows NORMAL
    p_reset_normal_r1: assert property (@(posedge clk)
        $past(rst) |-> (mode == 3'd0));
endmodule

// File: tb/burst_gate_ctrl_tb.sv
module burst_gate_ctrl_tb;
    localparam int CLK_PER = 10;
    localparam int SMOD    = 5;
    localparam int SPASS   = 2;
    localparam int EXITN   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cmp = 4'hF;
    logic       pwm_in = 1'b0;
    logic       gate_out;
    logic [2:0] mode;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER/2) clk = ~clk;

    burst_gate_ctrl #(
        .FILT_LEN(4), .SKIP_MOD(SMOD), .SKIP_PASS(SPASS), .EXIT_PERIODS(EXITN)
    ) u_dut (
        .clk(clk), .rst(rst),
        .fb_gt_600(cmp[3]), .fb_gt_500(cmp[2]), .fb_gt_400(cmp[1]), .fb_gt_300(cmp[0]),
        .pwm_in(pwm_in), .gate_out(gate_out), .mode(mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // level = number of thresholds the feedback is above (0..4)
    task automatic set_fb(input int lvl);
        for (int k = 0; k < 4; k++) cmp[k] = (lvl > k);
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse(input int w, output int hi);
        hi = 0;
        for (int i = 0; i < w; i++) begin
            pwm_in = 1'b1;
            #1;
            if (gate_out) hi++;
            @(negedge clk);
        end
        pwm_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(CLK_PER * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hi;
        int passed;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mode == 3'd0, "R1 reset mode", mode, 0);
        check(gate_out == 1'b0, "R1 reset gate", gate_out, 0);

        for (int p = 0; p < 3; p++) begin
            pulse(3, hi);
            check(hi == 3, "R3 normal pass", hi, 3);
        end

        // R2: 3-cycle glitch on the 600 mV flag
        cmp[3] = 1'b0;
        repeat (3) @(negedge clk);
        cmp[3] = 1'b1;
        repeat (12) @(negedge clk);
        check(mode == 3'd0, "R2 glitch ignored", mode, 0);

        set_fb(3);
        check(mode == 3'd1, "R3 enter fall", mode, 1);
        pulse(3, hi);
        check(hi == 3, "R4 fall pass", hi, 3);

        set_fb(2);
        check(mode == 3'd2, "R4 enter skip", mode, 2);
        passed = 0;
        for (int p = 0; p < 2 * SMOD; p++) begin
            pulse(3, hi);
            check(hi == (((p % SMOD) < SPASS) ? 3 : 0), "R5 skip pattern", hi,
                  ((p % SMOD) < SPASS) ? 3 : 0);
            if (hi != 0) passed++;
        end
        check(passed == 2 * SPASS, "R5 skip ratio", passed, 2 * SPASS);

        set_fb(1);
        check(mode == 3'd3, "R6 enter late", mode, 3);
        pulse(3, hi);
        check(hi == 3, "R6 late pass", hi, 3);

        set_fb(0);
        check(mode == 3'd4, "R6 enter off", mode, 4);
        pulse(3, hi);
        check(hi == 0, "R7 off blocks", hi, 0);

        set_fb(1);
        check(mode == 3'd5, "R7 enter rise", mode, 5);
        pulse(3, hi);
        check(hi == 3, "R8 rise pass", hi, 3);
        set_fb(2);
        set_fb(3);
        check(mode == 3'd5, "R8 rise holds", mode, 5);
        set_fb(4);
        for (int p = 0; p < EXITN - 1; p++) pulse(3, hi);
        check(mode == 3'd5, "R9 before exit", mode, 5);
        pulse(3, hi);
        check(hi == 3, "R9 last pulse passes", hi, 3);
        check(mode == 3'd0, "R9 exit to normal", mode, 0);

        // second round: peak then fall again
        for (int l = 3; l >= 0; l--) set_fb(l);
        for (int l = 1; l <= 4; l++) set_fb(l);
        check(mode == 3'd5, "R8 rise again", mode, 5);
        pulse(3, hi);
        pulse(3, hi);
        set_fb(3);
        check(mode == 3'd1, "R8 peak then fall", mode, 1);

        set_fb(0);
        check(mode == 3'd4, "R4 jump to off", mode, 4);

        // R10: state changes inside a long passed pulse
        set_fb(1);
        check(mode == 3'd5, "R10 setup rise", mode, 5);
        hi = 0;
        for (int i = 0; i < 16; i++) begin
            pwm_in = 1'b1;
            if (i == 2) cmp = 4'h0;
            #1;
            if (gate_out) hi++;
            @(negedge clk);
        end
        pwm_in = 1'b0;
        repeat (5) @(negedge clk);
        check(hi == 16, "R10 no truncation", hi, 16);
        check(mode == 3'd4, "R10 state moved", mode, 4);
        pulse(3, hi);
        check(hi == 0, "R10 next pulse blocked", hi, 0);

        // R1: reset in the middle of skipping
        set_fb(1);
        set_fb(4);
        for (int p = 0; p < EXITN; p++) pulse(3, hi);
        set_fb(3);
        set_fb(2);
        check(mode == 3'd2, "R1 setup skip", mode, 2);
        pulse(3, hi);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check(mode == 3'd0, "R1 reset forces normal", mode, 0);
        repeat (12) @(negedge clk);
        check(mode == 3'd2, "R1 reenter skip", mode, 2);
        for (int p = 0; p < SMOD; p++) begin
            pulse(3, hi);
            check(hi == ((p < SPASS) ? 3 : 0), "R1 skip counter cleared", hi,
                  (p < SPASS) ? 3 : 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule